// File: doc/BRIEF.md
# Typed Word Tag Guard

This block keeps a small type label beside every word of a tagged memory and enforces simple typing rules on it. Each word is labelled as one of five kinds: code, pointer, plain number, pointer/number pair, or empty. The label of an arithmetic result is derived automatically from the labels of its two operands. Only an explicit tag-write request may set a stored label directly.

Every instruction fetch is checked against the stored label. A fetch from a word that is not labelled as code stops the machine through a halt flag. The flag stays set until reset. When a word that was not code is relabelled as code, the block sends a one-cycle invalidate request carrying that word address, so that the translated-code cache can drop its stale copy.

Tag codes are: 0 empty, 1 code, 2 pointer, 3 number, 4 pair. Opcode codes are: 0 add, 1 subtract, 2 logic, 3 move. The label memory has a depth of `DEPTH` words, 256 by default, and reads take one cycle.

Top module: `tag_guard`

## Requirements
- R1: After reset, `res_valid`, `fx_valid`, `halt` and `inv_req` are 0. Every stored tag is 0 (empty), so a fetch made right after reset returns tag 0 and halts.
- R2: The cycle after `alu_en`, `res_tag` is 0 (empty) whenever either operand tag is 0 (empty) or 1 (code), for every opcode except move. For move, only `op_a_tag` matters, and a code or empty value gives 0.
- R3: Add (op 0) gives the following, one cycle after `alu_en`. Pointer(2) plus number(3), in either operand order, gives pointer(2). Number plus number gives number(3). Every other pairing gives empty(0).
- R4: Subtract (op 1) gives the following. Pointer minus pointer gives number(3). Pointer minus number gives pointer(2). Number minus number gives number(3). Every other pairing gives empty(0).
- R5: Logic (op 2) gives number(3) only for number with number, and empty(0) otherwise. Move (op 3) copies `op_a_tag` when it is 2, 3 or 4, and gives empty(0) otherwise.
- R6: A write with `tw_en` stores `tw_tag`. Codes 5 to 7 are stored as 0. A later fetch of that address returns the stored tag on `fx_tag`.
- R7: A fetch whose stored tag is not 1 raises `halt` in the same cycle that `fx_valid` presents the tag. A fetch whose tag is 1 leaves `halt` at 0.
- R8: Once raised, `halt` stays 1 until reset, whatever is fetched afterwards.
- R9: Writing tag 1 over a stored tag other than 1 makes `inv_req` high for exactly the next cycle, with `inv_addr` equal to `tw_addr`. Writing 1 over 1, or writing any other tag, leaves `inv_req` at 0.
- R10: A fetch and a write to the same address in the same cycle return the tag stored before the write, and the halt decision uses that tag.
- R11: `res_valid` and `fx_valid` are high only in the cycle after `alu_en` and `fx_en` respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_en | input | 1 | An ALU operation is issued this cycle |
| alu_op | input | 2 | Operation kind: 0 add, 1 subtract, 2 logic, 3 move |
| op_a_tag | input | 3 | Tag of the first operand |
| op_b_tag | input | 3 | Tag of the second operand |
| res_valid | output | 1 | `res_tag` is valid |
| res_tag | output | 3 | Derived result tag |
| tw_en | input | 1 | Tag write request |
| tw_addr | input | AW | Word address to relabel |
| tw_tag | input | 3 | New tag |
| fx_en | input | 1 | Fetch check request |
| fx_addr | input | AW | Fetched word address |
| fx_valid | output | 1 | `fx_tag` is valid |
| fx_tag | output | 3 | Stored tag of the fetched word |
| halt | output | 1 | Sticky stop after a fetch of a non-code word |
| inv_req | output | 1 | One-cycle invalidate pulse |
| inv_addr | output | AW | Address to invalidate |

## Verification
A write and a fetch can land on the same address in one cycle. The worst case is relabelling an empty word as code while the program counter is fetching it. The bench provokes this directly and also reaches it through random traffic over a narrow address window. It expects the fetch to report the old tag and to halt, while the invalidate pulse still fires in the same cycle as the fetch result. A second overlap drives an ALU result and a fetch result in the same cycle, and the bench checks both independently.

// File: rtl/tag_guard_pkg.sv
package tag_guard_pkg;

    typedef enum logic [2:0] {
        TG_EMPTY = 3'd0,
        TG_CODE  = 3'd1,
        TG_PTR   = 3'd2,
        TG_NUM   = 3'd3,
        TG_PAIR  = 3'd4
    } tag_e;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_SUB   = 2'd1,
        OP_LOGIC = 2'd2,
        OP_MOVE  = 2'd3
    } alu_kind_e;

    function automatic logic [2:0] clean_tag(input logic [2:0] t);
        return (t > 3'd4) ? 3'd0 : t;
    endfunction

endpackage

// File: rtl/tag_alu_rules.sv
module tag_alu_rules
    import tag_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alu_en,
    input  logic [1:0] alu_op,
    input  logic [2:0] a_tag,
    input  logic [2:0] b_tag,
    output logic       res_valid,
    output logic [2:0] res_tag
);

    typedef struct packed {
        logic       valid;
        logic [2:0] tag;
    } res_st_t;

    res_st_t st_d, st_q;
    logic [2:0] derived;
    logic       a_ptr, a_num, b_ptr, b_num;

    always_comb begin
        a_ptr = (a_tag == TG_PTR);
        a_num = (a_tag == TG_NUM);
        b_ptr = (b_tag == TG_PTR);
        b_num = (b_tag == TG_NUM);
        derived = TG_EMPTY;
        unique case (alu_op)
            OP_ADD: begin
                if ((a_ptr && b_num) || (a_num && b_ptr)) derived = TG_PTR;
                else if (a_num && b_num)                 derived = TG_NUM;
            end
            OP_SUB: begin
                if (a_ptr && b_ptr)      derived = TG_NUM;
                else if (a_ptr && b_num) derived = TG_PTR;
                else if (a_num && b_num) derived = TG_NUM;
            end
            OP_LOGIC: begin
                if (a_num && b_num) derived = TG_NUM;
            end
            default: begin
                if (a_ptr || a_num || (a_tag == TG_PAIR)) derived = a_tag;
            end
        endcase
        st_d.valid = alu_en;
        st_d.tag   = alu_en ? derived : st_q.tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.valid;
    assign res_tag   = st_q.tag;

    AST_POISON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_en && alu_op != OP_MOVE && (a_tag == TG_EMPTY || a_tag == TG_CODE || b_tag == TG_EMPTY || b_tag == TG_CODE))
        |=> (res_valid && res_tag == TG_EMPTY)); // R2
    AST_RES_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(alu_en)); // R11

endmodule

// File: rtl/tag_store.sv
module tag_store
    import tag_guard_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [2:0]    wr_tag,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_valid,
    output logic [2:0]    rd_tag,
    output logic [2:0]    old_tag
);

    typedef struct packed {
        logic       valid;
        logic [2:0] tag;
    } rd_st_t;

    logic [2:0] mem_d [DEPTH];
    logic [2:0] mem_q [DEPTH];
    rd_st_t     rd_d, rd_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (wr_en) mem_d[wr_addr] = clean_tag(wr_tag);
        rd_d.valid = rd_en;
        rd_d.tag   = rd_en ? mem_q[rd_addr] : rd_q.tag;
        old_tag    = mem_q[wr_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= TG_EMPTY;
            rd_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.valid;
    assign rd_tag   = rd_q.tag;

    AST_READ_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en)); // R11
    AST_CLEAN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_tag <= 3'd4)); // R6

endmodule

// File: rtl/code_guard.sv
module code_guard
    import tag_guard_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [2:0]    wr_tag,
    input  logic [2:0]    old_tag,
    input  logic          rd_valid,
    input  logic [2:0]    rd_tag,
    output logic          halt,
    output logic          inv_req,
    output logic [AW-1:0] inv_addr
);

    typedef struct packed {
        logic          stop;
        logic          inv;
        logic [AW-1:0] addr;
    } guard_st_t;

    guard_st_t st_d, st_q;
    logic      fault;

    always_comb begin
        fault     = rd_valid && (rd_tag != TG_CODE);
        st_d      = st_q;
        st_d.stop = st_q.stop | fault;
        st_d.inv  = wr_en && (wr_tag == TG_CODE) && (old_tag != TG_CODE);
        if (st_d.inv) st_d.addr = wr_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign halt     = st_q.stop | fault;
    assign inv_req  = st_q.inv;
    assign inv_addr = st_q.addr;

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt); // R8
    AST_INV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req |-> $past(wr_en && wr_tag == TG_CODE)); // R9
    AST_INV_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req |-> (inv_addr == $past(wr_addr))); // R9

endmodule

// File: rtl/tag_guard.sv
module tag_guard
    import tag_guard_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alu_en,
    input  logic [1:0]    alu_op,
    input  logic [2:0]    op_a_tag,
    input  logic [2:0]    op_b_tag,
    output logic          res_valid,
    output logic [2:0]    res_tag,
    input  logic          tw_en,
    input  logic [AW-1:0] tw_addr,
    input  logic [2:0]    tw_tag,
    input  logic          fx_en,
    input  logic [AW-1:0] fx_addr,
    output logic          fx_valid,
    output logic [2:0]    fx_tag,
    output logic          halt,
    output logic          inv_req,
    output logic [AW-1:0] inv_addr
);

    logic [2:0] old_tag;

    tag_alu_rules u_alu (
        .clk(clk), .rst_n(rst_n), .alu_en(alu_en), .alu_op(alu_op),
        .a_tag(op_a_tag), .b_tag(op_b_tag),
        .res_valid(res_valid), .res_tag(res_tag)
    );

    tag_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tw_en), .wr_addr(tw_addr), .wr_tag(tw_tag),
        .rd_en(fx_en), .rd_addr(fx_addr),
        .rd_valid(fx_valid), .rd_tag(fx_tag), .old_tag(old_tag)
    );

    code_guard #(.AW(AW)) u_guard (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tw_en), .wr_addr(tw_addr), .wr_tag(tw_tag), .old_tag(old_tag),
        .rd_valid(fx_valid), .rd_tag(fx_tag),
        .halt(halt), .inv_req(inv_req), .inv_addr(inv_addr)
    );

    AST_FETCH_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (fx_valid && fx_tag != TG_CODE) |-> halt); // R7

endmodule

// File: tb/tag_guard_test.sv
module tag_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 256;
    localparam int AW = $clog2(DEPTH);

    logic clk = 0, rst_n = 0;
    logic alu_en = 0; logic [1:0] alu_op = 0; logic [2:0] op_a_tag = 0, op_b_tag = 0;
    logic res_valid; logic [2:0] res_tag;
    logic tw_en = 0; logic [AW-1:0] tw_addr = 0; logic [2:0] tw_tag = 0;
    logic fx_en = 0; logic [AW-1:0] fx_addr = 0;
    logic fx_valid; logic [2:0] fx_tag; logic halt, inv_req; logic [AW-1:0] inv_addr;

    int tests = 0, fails = 0;
    logic [2:0] model [DEPTH];
    logic model_halt = 0;

    tag_guard #(.DEPTH(DEPTH)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    function automatic logic [2:0] exp_res(input logic [1:0] op, input logic [2:0] a, input logic [2:0] b);
        case (op)
            2'd0: if ((a == 2 && b == 3) || (a == 3 && b == 2)) return 3'd2;
                  else if (a == 3 && b == 3) return 3'd3; else return 3'd0;
            2'd1: if (a == 2 && b == 2) return 3'd3; else if (a == 2 && b == 3) return 3'd2;
                  else if (a == 3 && b == 3) return 3'd3; else return 3'd0;
            2'd2: return (a == 3 && b == 3) ? 3'd3 : 3'd0;
            default: return (a == 2 || a == 3 || a == 4) ? a : 3'd0;
        endcase
    endfunction

    function automatic string rule_of(input logic [1:0] op, input logic [2:0] a, input logic [2:0] b);
        if (op != 3 && (a <= 1 || b <= 1)) return "R2";
        if (op == 0) return "R3";
        if (op == 1) return "R4";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // one clock: drive at negedge, sample 1 unit after posedge
    task automatic cycle(input logic ae, input logic [1:0] op, input logic [2:0] a, input logic [2:0] b,
                         input logic we, input logic [AW-1:0] wa, input logic [2:0] wt,
                         input logic fe, input logic [AW-1:0] fa, input string freq);
        logic [2:0] e_fx; logic e_inv;
        @(negedge clk);
        alu_en = ae; alu_op = op; op_a_tag = a; op_b_tag = b;
        tw_en = we; tw_addr = wa; tw_tag = wt; fx_en = fe; fx_addr = fa;
        e_fx  = model[fa];
        e_inv = we && wt == 1 && model[wa] != 1;
        if (we) model[wa] = (wt > 4) ? 3'd0 : wt;
        if (fe && e_fx != 1) model_halt = 1;
        @(posedge clk); #1;
        check("R11 res_valid", res_valid, ae);
        if (ae) check(rule_of(op, a, b), res_tag, exp_res(op, a, b));
        check("R11 fx_valid", fx_valid, fe);
        if (fe) check(freq, fx_tag, e_fx);
        check("R7/R8 halt", halt, model_halt);
        check("R9 inv_req", inv_req, e_inv);
        if (e_inv) check("R9 inv_addr", inv_addr, wa);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        alu_en = 0; tw_en = 0; fx_en = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        for (int i = 0; i < DEPTH; i++) model[i] = 0;
        model_halt = 0;
    endtask

    initial begin
        logic [31:0] seed;
        seed = 32'd7;
        void'($urandom(seed));
        do_reset();
        #1;
        check("R1 res_valid", res_valid, 0);
        check("R1 fx_valid", fx_valid, 0);
        check("R1 halt", halt, 0);
        check("R1 inv_req", inv_req, 0);

        // R3 R4 R5 R2 directed ALU corners
        cycle(1, 0, 2, 3, 0, 0, 0, 0, 0, "R6");
        cycle(1, 0, 3, 2, 0, 0, 0, 0, 0, "R6");
        cycle(1, 1, 2, 2, 0, 0, 0, 0, 0, "R6");
        cycle(1, 1, 3, 2, 0, 0, 0, 0, 0, "R6");
        cycle(1, 2, 3, 3, 0, 0, 0, 0, 0, "R6");
        cycle(1, 3, 4, 0, 0, 0, 0, 0, 0, "R6");
        cycle(1, 3, 1, 3, 0, 0, 0, 0, 0, "R6");
        cycle(1, 0, 1, 3, 0, 0, 0, 0, 0, "R6");

        // R6 R9: relabel as code, invalid code 6 stored as empty
        cycle(0, 0, 0, 0, 1, 8'd10, 1, 0, 0, "R6");
        cycle(0, 0, 0, 0, 1, 8'd10, 1, 0, 0, "R6");   // R9 code over code: no pulse
        cycle(0, 0, 0, 0, 1, 8'd11, 6, 1, 8'd10, "R6");
        cycle(0, 0, 0, 0, 0, 0, 0, 1, 8'd11, "R6");   // R6 code 6 read as 0, halts (R7)
        // R8 sticky after fetching code
        cycle(0, 0, 0, 0, 0, 0, 0, 1, 8'd10, "R8");
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");

        // R1 reset clears tags and halt; fetch after reset reads empty
        do_reset();
        #1;
        check("R1 halt cleared", halt, 0);
        cycle(0, 0, 0, 0, 0, 0, 0, 1, 8'd10, "R1");

        // R10 same-cycle retag and fetch of the same word, with ALU overlap
        do_reset();
        cycle(1, 0, 3, 3, 1, 8'd20, 1, 1, 8'd20, "R10");
        cycle(0, 0, 0, 0, 0, 0, 0, 1, 8'd20, "R10");

        // random traffic over a narrow window; reset periodically to clear halt
        do_reset();
        for (int i = 0; i < 2000; i++) begin
            logic [1:0] op; logic [2:0] a, b, wt; logic [AW-1:0] wa, fa; logic fe;
            if (i % 250 == 0) begin
                do_reset();
                for (int k = 0; k < 8; k++) cycle(0, 0, 0, 0, 1, AW'(k), 1, 0, 0, "R6");
            end
            op = 2'($urandom); a = 3'($urandom); b = 3'($urandom);
            wt = ($urandom % 3 == 0) ? 3'd1 : 3'($urandom);
            wa = AW'($urandom % 8); fa = AW'($urandom % 8);
            fe = ($urandom % 2) == 0;
            cycle($urandom % 2 == 0, op, a, b, $urandom % 3 == 0, wa, wt, fe, fa, "R10/R6 fx_tag");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule